// File: doc/BRIEF.md
# Configuration Memory Address Sequencer

This block drives the readout side of a configuration memory that streams a stored bitstream into a programmable device. It keeps a word counter. The counter starts at the first word of a selected revision bank and advances once per rising clock edge. The current word is presented on the data output, together with separate enables that stand in for the tristate drivers of the data and clock pins.

When the last word of the range has been delivered, the sequencer hands off to the next memory in a daisy chain. It does this by pulling its active-low cascade output low, and it stops driving data. The counter then stays at the last word. It does not wrap.

Two active-low style controls govern operation:
- A high chip-select input puts the block into standby.
- A low output-enable/reset input holds the counter at the start of the range.

Both controls act asynchronously. A parameter fixes the output width at one bit (serial) or at several bits (parallel). A busy input can stall the counter, but only in parallel mode. A second parameter decides the range:
- With banking on, it is one of four equal revision banks.
- With banking off, it is the whole memory.

The memory contents come in through a parameter vector.

Top module: `cfgrom_seq`

## Requirements
- R1: While ce_n is high, data_oe and clk_oe are 0 and cascade_n is 1, whatever oe_rst_n is. The counter is forced to the start of the range, so after ce_n falls the first word presented is the range's first word.
- R2: While ce_n is low and oe_rst_n is low, data_oe and clk_oe are 0, cascade_n is 1 and the counter is held at the start of the range. Releasing oe_rst_n restarts the stream from the first word.
- R3: When ce_n is low, oe_rst_n is high, the range end has not been reached and no stall applies, each rising clock edge advances the address by exactly one word. data_o shows ROM_INIT[a*DATA_W +: DATA_W] for current address a.
- R4: Once the address equals the end of the range, it stays there on later edges. It never wraps, and data_o keeps showing the last word.
- R5: cascade_n goes low on the first unstalled rising edge taken while the address is at the range end. It returns high as soon as ce_n rises or oe_rst_n falls, and it is 1 in every other situation.
- R6: In parallel mode (DATA_W greater than 1), busy = 1 freezes the address and also delays the cascade handoff for as long as it is held.
- R7: In serial mode (DATA_W = 1), the busy input has no effect on the address or on the handoff.
- R8: With BANKING = 1, rev_sel = b selects words b*DEPTH/4 through b*DEPTH/4 + DEPTH/4 - 1. With BANKING = 0, the range is word 0 through word DEPTH-1 and rev_sel is ignored.
- R9: rev_sel is sampled only during standby or reset. Changing it while the block is streaming leaves the bank of the current stream unchanged.
- R10: clk_oe is 1 whenever ce_n is low and oe_rst_n is high. data_oe is 1 under the same condition only until the handoff, and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock, rising edge active |
| ce_n | input | 1 | Chip select, active low; high selects standby |
| oe_rst_n | input | 1 | Output enable, active high; low holds the counter at the range start |
| busy | input | 1 | Stall request, honoured in parallel mode only |
| rev_sel | input | 2 | Revision bank select |
| data_o | output | DATA_W | Word at the current address |
| data_oe | output | 1 | Data pin drive enable |
| clk_oe | output | 1 | Clock pin drive enable |
| cascade_n | output | 1 | Active-low enable for the next chained memory |

## Verification
The checker's properties assume the two controls change only between clock edges. They also assume rev_sel is steady for at least one clock edge before the block leaves standby or reset, so that the captured bank matches the input seen during the hold. The bench changes every input one time unit after a rising edge. It always holds the reset or standby condition across two edges with rev_sel already set before it releases the controls. The only time rev_sel moves mid-stream is the scenario that checks that such a change is ignored.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

  // Strobes from the control half to the address datapath
  typedef struct packed {
    logic clear;      // asynchronous hold of the word offset
    logic step;       // advance the offset on this edge
    logic sampleRev;  // capture the revision select on this edge
  } seqStrobe_t;

  typedef enum logic {
    PH_STREAM  = 1'b0,
    PH_HANDOFF = 1'b1
  } phase_t;

endpackage

// File: rtl/cfgrom_ctl.sv
module cfgrom_ctl
  import cfgrom_pkg::*;
#(
  parameter bit PARALLEL = 1'b1
) (
  input  logic       clk,
  input  logic       ce_n,
  input  logic       oe_rst_n,
  input  logic       busy,
  input  logic       atEnd,
  output seqStrobe_t strb,
  output logic       data_oe,
  output logic       clk_oe,
  output logic       cascade_n
);

  logic   holdRst;
  logic   stall;
  logic   finish;
  phase_t phase;

  assign holdRst = ce_n | ~oe_rst_n;
  assign stall   = PARALLEL & busy;
  assign finish  = ~holdRst & ~stall & atEnd & (phase == PH_STREAM);

  always_ff @(posedge clk or posedge holdRst) begin
    if (holdRst)     phase <= PH_STREAM;
    else if (finish) phase <= PH_HANDOFF;
  end

  always_comb begin
    strb.clear     = holdRst;
    strb.sampleRev = holdRst;
    strb.step      = ~holdRst & ~stall & ~atEnd;
  end

  assign clk_oe    = ~holdRst;
  assign data_oe   = ~holdRst & (phase == PH_STREAM);
  assign cascade_n = ~(~holdRst & (phase == PH_HANDOFF));

endmodule

// File: rtl/cfgrom_dp.sv
module cfgrom_dp
  import cfgrom_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter bit BANKING = 1'b1
) (
  input  logic                     clk,
  input  seqStrobe_t               strb,
  input  logic [1:0]               rev_sel,
  output logic [$clog2(DEPTH)-1:0] curAddr,
  output logic                     atEnd
);

  localparam int ADDR_W     = $clog2(DEPTH);
  localparam int BANK_WORDS = DEPTH / 4;
  localparam int BOFF_W     = $clog2(BANK_WORDS);

  logic              clrAsync;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] lastOff;
  logic [1:0]        bankReg;
  logic [1:0]        bankEff;

  assign clrAsync = strb.clear;

  // Revision select is captured only while held
  always_ff @(posedge clk) begin
    if (strb.sampleRev) bankReg <= rev_sel;
  end
  assign bankEff = strb.sampleRev ? rev_sel : bankReg;

  generate
    if (BANKING) begin : g_bank
      assign base    = {bankEff, BOFF_W'(0)};
      assign lastOff = ADDR_W'(BANK_WORDS - 1);
    end else begin : g_flat
      assign base    = '0;
      assign lastOff = ADDR_W'(DEPTH - 1);
    end
  endgenerate

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync)       offset <= '0;
    else if (strb.step) offset <= offset + 1'b1;
  end

  assign curAddr = base + offset;
  assign atEnd   = (offset == lastOff);

endmodule

// File: rtl/cfgrom_rom.sv
module cfgrom_rom #(
  parameter int                      DEPTH    = 64,
  parameter int                      DATA_W   = 8,
  parameter logic [DEPTH*DATA_W-1:0] ROM_INIT = '0
) (
  input  logic [$clog2(DEPTH)-1:0] curAddr,
  output logic [DATA_W-1:0]        data_o
);

  logic [DATA_W-1:0] romArr [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
      assign romArr[i] = ROM_INIT[i*DATA_W +: DATA_W];
    end
  endgenerate

  assign data_o = romArr[curAddr];

endmodule

// File: rtl/cfgrom_seq.sv
module cfgrom_seq
  import cfgrom_pkg::*;
#(
  parameter int                      DEPTH    = 64,
  parameter int                      DATA_W   = 8,
  parameter bit                      BANKING  = 1'b1,
  parameter logic [DEPTH*DATA_W-1:0] ROM_INIT = '0
) (
  input  logic              clk,
  input  logic              ce_n,
  input  logic              oe_rst_n,
  input  logic              busy,
  input  logic [1:0]        rev_sel,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              clk_oe,
  output logic              cascade_n
);

  localparam int ADDR_W   = $clog2(DEPTH);
  localparam bit PARALLEL = (DATA_W > 1);

  seqStrobe_t        strb;
  logic              atEnd;
  logic [ADDR_W-1:0] curAddr;

  cfgrom_ctl #(.PARALLEL(PARALLEL)) ctl_i (
    .clk(clk), .ce_n(ce_n), .oe_rst_n(oe_rst_n), .busy(busy),
    .atEnd(atEnd), .strb(strb), .data_oe(data_oe), .clk_oe(clk_oe),
    .cascade_n(cascade_n)
  );

  cfgrom_dp #(.DEPTH(DEPTH), .BANKING(BANKING)) dp_i (
    .clk(clk), .strb(strb), .rev_sel(rev_sel),
    .curAddr(curAddr), .atEnd(atEnd)
  );

  cfgrom_rom #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ROM_INIT(ROM_INIT)) rom_i (
    .curAddr(curAddr), .data_o(data_o)
  );

endmodule

// File: rtl/cfgrom_seq_chk.sv
module cfgrom_seq_chk #(
  parameter int ADDR_W   = 6,
  parameter bit PARALLEL = 1'b1
) (
  input logic              clk,
  input logic              ce_n,
  input logic              oe_rst_n,
  input logic              busy,
  input logic              data_oe,
  input logic              clk_oe,
  input logic              cascade_n,
  input logic [ADDR_W-1:0] curAddr,
  input logic              atEnd
);

  // R1
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!oe_rst_n)
    ce_n |-> (!data_oe && !clk_oe && cascade_n));

  // R2
  oe_hold_quiet_chk: assert property (@(posedge clk) disable iff (ce_n)
    !oe_rst_n |-> (!data_oe && !clk_oe && cascade_n));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (ce_n || !oe_rst_n)
    (!atEnd && !(PARALLEL && busy)) |=> (curAddr == ADDR_W'($past(curAddr) + 1'b1)));

  // R4
  end_saturate_chk: assert property (@(posedge clk) disable iff (ce_n || !oe_rst_n)
    atEnd |=> ($stable(curAddr) && atEnd));

  // R6
  busy_freeze_chk: assert property (@(posedge clk) disable iff (ce_n || !oe_rst_n)
    (PARALLEL && busy) |=> $stable(curAddr));

  // R5
  handoff_at_end_chk: assert property (@(posedge clk) disable iff (ce_n || !oe_rst_n)
    !cascade_n |-> (atEnd && !data_oe));

  // R10
  clk_drive_chk: assert property (@(posedge clk) disable iff (ce_n || !oe_rst_n)
    clk_oe && (data_oe != !cascade_n));

endmodule

bind cfgrom_seq cfgrom_seq_chk #(.ADDR_W(ADDR_W), .PARALLEL(PARALLEL)) chk_i (
  .clk(clk), .ce_n(ce_n), .oe_rst_n(oe_rst_n), .busy(busy),
  .data_oe(data_oe), .clk_oe(clk_oe), .cascade_n(cascade_n),
  .curAddr(curAddr), .atEnd(atEnd)
);

// File: tb/cfgrom_seq_tb_top.sv
module cfgrom_seq_tb_top;

  localparam int DEPTH = 64;
  localparam int BANKW = DEPTH / 4;
  localparam logic [63:0] SER_ROM = 64'hC3A5_1F0E_96D2_7B48;

  function automatic logic [7:0] parWord(int a);
    return 8'((a * 37 + 11) % 256);
  endfunction

  function automatic logic [DEPTH*8-1:0] buildRom();
    logic [DEPTH*8-1:0] v;
    for (int a = 0; a < DEPTH; a++) v[a*8 +: 8] = parWord(a);
    return v;
  endfunction

  localparam logic [DEPTH*8-1:0] PAR_ROM = buildRom();

  logic       clk = 1'b0;
  logic       ce_n = 1'b1;
  logic       oe_rst_n = 1'b0;
  logic       busy = 1'b0;
  logic [1:0] rev_sel = 2'd0;
  logic [7:0] data_o;
  logic       data_oe, clk_oe, cascade_n;
  logic       sData, sDataOe, sClkOe, sCascade;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  cfgrom_seq #(.DEPTH(DEPTH), .DATA_W(8), .BANKING(1'b1), .ROM_INIT(PAR_ROM)) dut_i (
    .clk(clk), .ce_n(ce_n), .oe_rst_n(oe_rst_n), .busy(busy), .rev_sel(rev_sel),
    .data_o(data_o), .data_oe(data_oe), .clk_oe(clk_oe), .cascade_n(cascade_n)
  );

  cfgrom_seq #(.DEPTH(DEPTH), .DATA_W(1), .BANKING(1'b0), .ROM_INIT(SER_ROM)) dut_s (
    .clk(clk), .ce_n(ce_n), .oe_rst_n(oe_rst_n), .busy(busy), .rev_sel(rev_sel),
    .data_o(sData), .data_oe(sDataOe), .clk_oe(sClkOe), .cascade_n(sCascade)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  // Hold in standby with a bank chosen, then release
  task automatic startBank(int b);
    rev_sel  = 2'(b);
    ce_n     = 1'b1;
    oe_rst_n = 1'b1;
    tick();
    tick();
    ce_n = 1'b0;
    #1;
  endtask

  task automatic testReset();
    check("R1", "standby data_oe", 32'(data_oe), 0);
    check("R1", "standby clk_oe", 32'(clk_oe), 0);
    check("R1", "standby cascade_n", 32'(cascade_n), 1);
    check("R1", "standby start word", 32'(data_o), 32'(parWord(0)));
  endtask

  task automatic testBankRun(int b, bit swapRev);
    int first;
    first = b * BANKW;
    startBank(b);
    check("R8", "bank first word", 32'(data_o), 32'(parWord(first)));
    check("R10", "data_oe while streaming", 32'(data_oe), 1);
    check("R10", "clk_oe while streaming", 32'(clk_oe), 1);
    if (swapRev) rev_sel = ~2'(b);
    for (int k = 1; k < BANKW; k++) begin
      tick();
      if (swapRev) check("R9", "word after rev change", 32'(data_o), 32'(parWord(first + k)));
      else         check("R3", "word step", 32'(data_o), 32'(parWord(first + k)));
      check("R5", "no early handoff", 32'(cascade_n), 1);
    end
    tick();
    check("R5", "handoff cascade_n", 32'(cascade_n), 0);
    check("R10", "data_oe after handoff", 32'(data_oe), 0);
    check("R10", "clk_oe after handoff", 32'(clk_oe), 1);
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R4", "saturated word", 32'(data_o), 32'(parWord(first + BANKW - 1)));
      check("R4", "handoff kept", 32'(cascade_n), 0);
    end
    oe_rst_n = 1'b0;
    #1;
    check("R5", "cascade_n rises on oe low", 32'(cascade_n), 1);
    oe_rst_n = 1'b1;
    ce_n = 1'b1;
    #1;
    check("R1", "cascade_n in standby", 32'(cascade_n), 1);
  endtask

  task automatic testOeHold();
    startBank(1);
    for (int k = 0; k < 5; k++) tick();
    check("R3", "mid-stream word", 32'(data_o), 32'(parWord(BANKW + 5)));
    oe_rst_n = 1'b0;
    #1;
    check("R2", "oe low data_oe", 32'(data_oe), 0);
    check("R2", "oe low clk_oe", 32'(clk_oe), 0);
    check("R2", "oe low cascade_n", 32'(cascade_n), 1);
    check("R2", "oe low address held", 32'(data_o), 32'(parWord(BANKW)));
    tick();
    tick();
    check("R2", "still held", 32'(data_o), 32'(parWord(BANKW)));
    oe_rst_n = 1'b1;
    #1;
    check("R2", "restart word", 32'(data_o), 32'(parWord(BANKW)));
    tick();
    check("R2", "restart step", 32'(data_o), 32'(parWord(BANKW + 1)));
    ce_n = 1'b1;
    tick();
    check("R1", "standby resets address", 32'(data_o), 32'(parWord(BANKW)));
  endtask

  task automatic testBusy();
    int first;
    first = 2 * BANKW;
    startBank(2);
    for (int k = 0; k < 4; k++) tick();
    busy = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R6", "busy freezes word", 32'(data_o), 32'(parWord(first + 4)));
    end
    busy = 1'b0;
    tick();
    check("R6", "resume after busy", 32'(data_o), 32'(parWord(first + 5)));
    for (int k = 6; k < BANKW; k++) tick();
    check("R3", "reached end word", 32'(data_o), 32'(parWord(first + BANKW - 1)));
    busy = 1'b1;
    tick();
    tick();
    check("R6", "busy delays handoff", 32'(cascade_n), 1);
    check("R6", "busy keeps data_oe", 32'(data_oe), 1);
    busy = 1'b0;
    tick();
    check("R5", "handoff after busy", 32'(cascade_n), 0);
    ce_n = 1'b1;
    tick();
  endtask

  task automatic testSerial();
    busy = 1'b1;
    startBank(3);
    check("R8", "serial starts at word 0", 32'(sData), 32'(SER_ROM[0]));
    for (int k = 1; k < DEPTH; k++) begin
      tick();
      check("R7", "serial bit with busy high", 32'(sData), 32'(SER_ROM[k]));
    end
    check("R7", "serial no early handoff", 32'(sCascade), 1);
    tick();
    check("R7", "serial handoff with busy high", 32'(sCascade), 0);
    check("R10", "serial data_oe off", 32'(sDataOe), 0);
    busy = 1'b0;
    ce_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    testReset();
    for (int b = 0; b < 4; b++) testBankRun(b, 1'b0);
    testBankRun(1, 1'b1);
    testOeHold();
    testBusy();
    testSerial();
    finishRun();
  end

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

endmodule